// File: doc/BRIEF.md
# Character Display Instruction Decoder

This block is the command engine on the device side of a character display controller. A host presents one bus cycle per clock on `bus_valid`, made of a register-select bit, a read/write bit and a byte. With select low, a write carries an instruction and a read returns status. With select high, the cycle reads or writes one byte of the selected character RAM. The opcode of an instruction is the position of the highest set bit of its byte. Every instruction updates the address counter, the mode flags or the RAM contents.

Each accepted instruction or data access starts a busy period of a fixed number of clock (oscillator) cycles that depends on the opcode. While it runs, only the status read is served and every other cycle is dropped. The host polls status until the busy bit clears. Two RAMs are held inside: a 128-byte display RAM and a 64-byte glyph RAM. A single 7-bit address counter points into whichever one was selected last. It steps after every data access in the direction set by the entry mode.

Top module: `chardisp_cmd_engine`

## Requirements
- R1: After reset, busy is 0, `incr` and `wide_bus` are 1, all other mode outputs and `shift_pos` are 0, the display RAM is selected, and a status read returns 8'h00.
- R2: Instruction byte 8'h01 fills all 128 display RAM bytes with 8'h20, loads the address counter with 0, selects display RAM, and sets `shift_pos` to 0.
- R3: Instruction byte 0000001x loads the address counter with 0, selects display RAM and sets `shift_pos` to 0, and leaves the RAM contents unchanged.
- R4: Instruction byte 000001ab sets `incr` to a (bit 1) and `auto_shift` to b (bit 0).
- R5: Instruction byte 00001dcb sets `disp_on` from bit 2, `cursor_on` from bit 1 and `blink_on` from bit 0.
- R6: Instruction byte 0001sdxx changes no RAM byte. With s (bit 3) = 1 it adds 1 to `shift_pos` when d (bit 2) = 1 and subtracts 1 when d = 0, modulo 128. With s = 0 it steps the address counter up (d = 1) or down (d = 0) by the rules of R9.
- R7: Instruction byte 001abcxx sets `wide_bus` from bit 4, `two_line` from bit 3 and `tall_font` from bit 2.
- R8: Byte 01aaaaaa selects glyph RAM and loads the address counter with {0, aaaaaa}. Byte 1aaaaaaa selects display RAM and loads the counter with aaaaaaa. Data accesses that follow target the selected RAM.
- R9: A data write (select 1, rw 0) stores the byte at the address counter. A data read (select 1, rw 1) returns the byte on `rd_data` with `rd_valid` high on the cycle after the bus cycle. After either one, the counter steps +1 if `incr` is set and -1 otherwise, wrapping modulo 128 in display RAM and modulo 64 in glyph RAM. If `auto_shift` is set, `shift_pos` also steps (-1 when `incr` is set, +1 otherwise).
- R10: `busy` is high for exactly T_LONG cycles after R2/R3, T_SHORT cycles after R4 through R8, and T_DATA cycles after a data access, starting the cycle after the accepting edge.
- R11: While `busy` is high, instruction writes and data accesses have no effect: the address counter, mode outputs and RAM are unchanged, and no `rd_valid` follows.
- R12: A status read (select 0, rw 1) is served at any time and changes no state. On the next cycle `rd_valid` is 1 and `rd_data` is {busy, address counter}, both as they were during the read cycle.
- R13: Instruction byte 8'h00 changes nothing and starts no busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_rs | input | 1 | 0 = instruction/status, 1 = RAM data |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_wdata | input | 8 | Instruction or data byte |
| rd_valid | output | 1 | rd_data holds a read result |
| rd_data | output | 8 | Status or RAM byte |
| busy | output | 1 | Instruction in execution |
| disp_on | output | 1 | Display enable flag |
| cursor_on | output | 1 | Cursor visible flag |
| blink_on | output | 1 | Cursor blink flag |
| incr | output | 1 | Address steps upward after data access |
| auto_shift | output | 1 | Display shifts on data access |
| wide_bus | output | 1 | 8-bit interface flag |
| two_line | output | 1 | Two-line flag |
| tall_font | output | 1 | Tall font flag |
| shift_pos | output | 7 | Accumulated display shift (modulo 128) |

## Verification
A wrong address counter shows up at the first status read after it goes wrong, and also at the next data read, which returns the wrong byte. A wrong RAM selection or wrap shows up when later reads return stale bytes. A fault in the busy counter shows up in the very cycle it goes wrong, because the bench compares `busy` against its own countdown on every clock. A dropped or accepted-while-busy instruction appears one cycle later on the mode outputs, or at the next status read as a counter value the host did not expect.

// File: rtl/chardisp_cmd_engine.sv
module chardisp_cmd_engine #(
  parameter int T_SHORT = 10,
  parameter int T_LONG  = 411,
  parameter int T_DATA  = 2,
  parameter int CW      = $clog2(T_LONG + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_valid,
  input  logic       bus_rs,
  input  logic       bus_rw,
  input  logic [7:0] bus_wdata,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       busy,
  output logic       disp_on,
  output logic       cursor_on,
  output logic       blink_on,
  output logic       incr,
  output logic       auto_shift,
  output logic       wide_bus,
  output logic       two_line,
  output logic       tall_font,
  output logic [6:0] shift_pos
);
  typedef enum logic [3:0] {
    OP_NOP, OP_CLR, OP_HOME, OP_ENTRY, OP_DISP, OP_MOVE, OP_FUNC, OP_GADR, OP_DADR
  } op_t;

  localparam int DD_N = 128;
  localparam int CG_N = 64;

  logic [7:0]    dd_mem [DD_N];
  logic [7:0]    cg_mem [CG_N];
  logic [6:0]    ac;
  logic          sel_cg;
  logic [CW-1:0] bcnt;
  op_t           op;

  assign busy = bcnt != '0;

  wire stat_rd = bus_valid & ~bus_rs & bus_rw;
  wire acc     = bus_valid & ~busy & ~stat_rd;
  wire ins     = acc & ~bus_rs;
  wire dat     = acc & bus_rs;

  always_comb begin
    casez (bus_wdata)
      8'b1???????: op = OP_DADR;
      8'b01??????: op = OP_GADR;
      8'b001?????: op = OP_FUNC;
      8'b0001????: op = OP_MOVE;
      8'b00001???: op = OP_DISP;
      8'b000001??: op = OP_ENTRY;
      8'b0000001?: op = OP_HOME;
      8'b00000001: op = OP_CLR;
      default:     op = OP_NOP;
    endcase
  end

  function automatic logic [6:0] step(input logic [6:0] a, input logic cg, input logic up);
    logic [6:0] n;
    n = up ? a + 7'd1 : a - 7'd1;
    if (cg) n[6] = 1'b0;
    return n;
  endfunction

  wire [7:0] mem_q = sel_cg ? cg_mem[ac[5:0]] : dd_mem[ac];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_data    <= 8'h00;
      bcnt       <= '0;
      ac         <= 7'd0;
      sel_cg     <= 1'b0;
      disp_on    <= 1'b0;
      cursor_on  <= 1'b0;
      blink_on   <= 1'b0;
      incr       <= 1'b1;
      auto_shift <= 1'b0;
      wide_bus   <= 1'b1;
      two_line   <= 1'b0;
      tall_font  <= 1'b0;
      shift_pos  <= 7'd0;
    end else begin
      rd_valid <= 1'b0;
      if (busy) bcnt <= bcnt - 1'b1;
      if (stat_rd) begin
        rd_valid <= 1'b1;
        rd_data  <= {busy, ac};
      end
      if (ins) begin
        case (op)
          OP_CLR, OP_HOME: begin
            ac        <= 7'd0;
            sel_cg    <= 1'b0;
            shift_pos <= 7'd0;
            bcnt      <= CW'(T_LONG);
          end
          OP_ENTRY: begin
            incr       <= bus_wdata[1];
            auto_shift <= bus_wdata[0];
            bcnt       <= CW'(T_SHORT);
          end
          OP_DISP: begin
            disp_on   <= bus_wdata[2];
            cursor_on <= bus_wdata[1];
            blink_on  <= bus_wdata[0];
            bcnt      <= CW'(T_SHORT);
          end
          OP_MOVE: begin
            if (bus_wdata[3]) shift_pos <= bus_wdata[2] ? shift_pos + 7'd1 : shift_pos - 7'd1;
            else ac <= step(ac, sel_cg, bus_wdata[2]);
            bcnt <= CW'(T_SHORT);
          end
          OP_FUNC: begin
            wide_bus  <= bus_wdata[4];
            two_line  <= bus_wdata[3];
            tall_font <= bus_wdata[2];
            bcnt      <= CW'(T_SHORT);
          end
          OP_GADR: begin
            ac     <= {1'b0, bus_wdata[5:0]};
            sel_cg <= 1'b1;
            bcnt   <= CW'(T_SHORT);
          end
          OP_DADR: begin
            ac     <= bus_wdata[6:0];
            sel_cg <= 1'b0;
            bcnt   <= CW'(T_SHORT);
          end
          default: ;
        endcase
      end
      if (dat) begin
        if (bus_rw) begin
          rd_valid <= 1'b1;
          rd_data  <= mem_q;
        end
        ac <= step(ac, sel_cg, incr);
        if (auto_shift) shift_pos <= incr ? shift_pos - 7'd1 : shift_pos + 7'd1;
        bcnt <= CW'(T_DATA);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ins && op == OP_CLR) begin
      for (int i = 0; i < DD_N; i++) dd_mem[i] <= 8'h20;
    end else if (dat && !bus_rw) begin
      if (sel_cg) cg_mem[ac[5:0]] <= bus_wdata;
      else dd_mem[ac] <= bus_wdata;
    end
  end
endmodule

// File: rtl/chardisp_cmd_engine_chk.sv
module chardisp_cmd_engine_chk #(
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_rs,
  input logic          bus_rw,
  input logic [7:0]    bus_wdata,
  input logic          rd_valid,
  input logic [7:0]    rd_data,
  input logic          busy,
  input logic [7:0]    modes,
  input logic [6:0]    shift_pos,
  input logic [6:0]    ac,
  input logic          sel_cg,
  input logic [CW-1:0] bcnt
);
  wire stat_rd = bus_valid & ~bus_rs & bus_rw;

  a_r11_busy_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bus_valid && !stat_rd |=> $stable(ac) && $stable(sel_cg) && $stable(modes) && !rd_valid);

  a_r12_status_read: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> rd_valid && rd_data == {$past(busy), $past(ac)});

  a_r10_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt != '0 |=> bcnt == $past(bcnt) - 1'b1);

  a_r2_home_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && bus_valid && !bus_rs && !bus_rw && bus_wdata[7:2] == 6'd0 && bus_wdata[1:0] != 2'd0
    |=> ac == 7'd0 && !sel_cg && shift_pos == 7'd0 && busy);

  a_r8_glyph_range: assert property (@(posedge clk) disable iff (!rst_n)
    sel_cg |-> !ac[6]);

  a_r9_read_source: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bus_valid && bus_rw));
endmodule

bind chardisp_cmd_engine chardisp_cmd_engine_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_rs(bus_rs), .bus_rw(bus_rw),
  .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
  .modes({disp_on, cursor_on, blink_on, incr, auto_shift, wide_bus, two_line, tall_font}),
  .shift_pos(shift_pos), .ac(ac), .sel_cg(sel_cg), .bcnt(bcnt)
);

// File: tb/test_chardisp_cmd_engine.sv
module test_chardisp_cmd_engine;
  localparam int T_SHORT = 10, T_LONG = 411, T_DATA = 2;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_rs = 0, bus_rw = 0;
  logic [7:0] bus_wdata = 0;
  logic rd_valid, busy, disp_on, cursor_on, blink_on, incr, auto_shift, wide_bus, two_line, tall_font;
  logic [7:0] rd_data;
  logic [6:0] shift_pos;

  always #10 clk = ~clk;

  chardisp_cmd_engine #(.T_SHORT(T_SHORT), .T_LONG(T_LONG), .T_DATA(T_DATA)) i_chardisp_cmd_engine (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_rs(bus_rs), .bus_rw(bus_rw),
    .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
    .disp_on(disp_on), .cursor_on(cursor_on), .blink_on(blink_on), .incr(incr),
    .auto_shift(auto_shift), .wide_bus(wide_bus), .two_line(two_line), .tall_font(tall_font),
    .shift_pos(shift_pos));

  int checks = 0, fails = 0;
  logic [7:0] md [128];
  logic [7:0] mc [64];
  logic [6:0] m_ac = 0, m_sh = 0;
  logic m_cg = 0;
  logic [7:0] m_mode = 8'b0001_0100;
  int m_busy = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] nxt(input logic [6:0] a, input logic cg, input logic up);
    logic [6:0] n;
    n = up ? a + 7'd1 : a - 7'd1;
    if (cg) n[6] = 1'b0;
    return n;
  endfunction

  task automatic step(input logic v, input logic rs, input logic rw, input logic [7:0] d);
    logic st, acc, pre, ev;
    logic [7:0] er;
    bus_valid = v; bus_rs = rs; bus_rw = rw; bus_wdata = d;
    st = v && !rs && rw;
    pre = m_busy != 0;
    acc = v && !pre && !st;
    ev = 0; er = 0;
    @(negedge clk);
    if (m_busy > 0) m_busy--;
    if (st) begin ev = 1; er = {pre, m_ac}; end
    if (acc && !rs) begin
      if (d[7]) begin m_ac = d[6:0]; m_cg = 0; m_busy = T_SHORT; end
      else if (d[6]) begin m_ac = {1'b0, d[5:0]}; m_cg = 1; m_busy = T_SHORT; end
      else if (d[5]) begin m_mode[2:0] = d[4:2]; m_busy = T_SHORT; end
      else if (d[4]) begin
        if (d[3]) m_sh = d[2] ? m_sh + 7'd1 : m_sh - 7'd1;
        else m_ac = nxt(m_ac, m_cg, d[2]);
        m_busy = T_SHORT;
      end
      else if (d[3]) begin m_mode[7:5] = d[2:0]; m_busy = T_SHORT; end
      else if (d[2]) begin m_mode[4:3] = d[1:0]; m_busy = T_SHORT; end
      else if (d[1] || d[0]) begin
        if (!d[1]) for (int i = 0; i < 128; i++) md[i] = 8'h20;
        m_ac = 0; m_cg = 0; m_sh = 0; m_busy = T_LONG;
      end
    end
    if (acc && rs) begin
      if (rw) begin ev = 1; er = m_cg ? mc[m_ac[5:0]] : md[m_ac]; end
      else if (m_cg) mc[m_ac[5:0]] = d;
      else md[m_ac] = d;
      if (m_mode[3]) m_sh = m_mode[4] ? m_sh - 7'd1 : m_sh + 7'd1;
      m_ac = nxt(m_ac, m_cg, m_mode[4]);
      m_busy = T_DATA;
    end
    chk("R10 busy", busy, m_busy != 0);
    chk("R11/R12 rd_valid", rd_valid, ev);
    if (ev) chk("R9/R12 rd_data", rd_data, er);
    chk("R4 R5 R7 modes", {disp_on, cursor_on, blink_on, incr, auto_shift, wide_bus, two_line, tall_font}, m_mode);
    chk("R6 shift_pos", shift_pos, m_sh);
    bus_valid = 0;
  endtask

  task automatic idle_until_free();
    while (m_busy != 0) step(0, 0, 0, 0);
  endtask

  task automatic status(input string req, input logic [7:0] exp);
    step(1, 0, 1, 0);
    chk(req, rd_data, exp);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset modes", {disp_on, cursor_on, blink_on, incr, auto_shift, wide_bus, two_line, tall_font}, 8'b0001_0100);
    chk("R1 reset shift", shift_pos, 0);
    status("R1 reset status", 8'h00);
    step(1, 0, 0, 8'h01);                      // R2 clear
    step(1, 0, 0, 8'h0F);                      // R11 ignored while busy
    step(1, 1, 0, 8'hAA);                      // R11 data write ignored
    status("R12 status during busy", 8'h80);
    idle_until_free();
    status("R2 counter after clear", 8'h00);
    step(1, 0, 0, 8'h40); idle_until_free();   // R8 glyph RAM at 0
    for (int i = 0; i < 64; i++) begin step(1, 1, 0, 8'($urandom)); idle_until_free(); end
    status("R9 glyph wrap up", 8'h00);
    step(1, 0, 0, 8'hFF); idle_until_free();   // R8 display address 127
    step(1, 1, 0, 8'h5A); idle_until_free();
    status("R9 display wrap up", 8'h00);
    step(1, 0, 0, 8'h04); idle_until_free();   // R4 decrement
    step(1, 0, 0, 8'h40); idle_until_free();
    step(1, 1, 1, 0); idle_until_free();
    status("R9 glyph wrap down", 8'h3F);
    step(1, 0, 0, 8'h03); idle_until_free();   // R3 home
    status("R3 home counter", 8'h00);
    step(1, 0, 0, 8'hFF); idle_until_free();
    step(1, 1, 1, 0);                          // R3 contents kept
    chk("R3 RAM kept", rd_data, 8'h5A);
    idle_until_free();
    step(1, 0, 0, 8'h00);                      // R13 no-op
    chk("R13 no busy", busy, 0);
    step(1, 0, 0, 8'h07); idle_until_free();   // R4 incr + shift
    step(1, 1, 0, 8'h33); idle_until_free();
    chk("R9 auto shift", shift_pos, 7'h7F);
    for (int n = 0; n < 5000; n++) begin
      int r, k;
      logic [7:0] b;
      r = $urandom % 10;
      if (r < 2) step(1, 0, 1, 0);
      else if (r < 6) begin
        k = $urandom % 9;
        if ((k == 1 || k == 2) && ($urandom % 6) != 0) k = k + 3;
        b = (k == 0) ? 8'h00 : 8'((1 << (k - 1)) | ($urandom & ((1 << (k - 1)) - 1)));
        step(1, 0, 0, b);
      end
      else if (r < 9) step(1, 1, 1'($urandom), 8'($urandom));
      else if ($urandom % 2) idle_until_free();
      else step(0, 0, 0, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule